// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer run through one 32-bit control word. The word carries a start count, a run command and a 7-bit key. A slow tick-enable input, generated outside the block, steps a down-counter. Once the watchdog is running, software keeps it alive by rewriting the control word. Each such rewrite must carry the bitwise complement of the key that is currently stored. A rewrite with any other key changes nothing.

When the count runs out, the watchdog does not reset the system at once. The first expiry raises a non-maskable interrupt and restarts the counter with a fixed grace count. If that grace count also runs out, the block issues a one-cycle system reset request and stops. An accepted write at any point cancels the interrupt stage.

The controller has four states. IDLE means stopped. RUN means counting from the loaded value. GRACE means counting the grace period with the interrupt raised. TRIPPED means stopped after the reset request, with the interrupt still raised. The transitions are:
- Any state goes to RUN on an accepted write with run = 1, and to IDLE on an accepted write with run = 0.
- RUN goes to GRACE on the expiring tick.
- GRACE goes to TRIPPED on the expiring tick.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control word reads 0, the counter is stopped, `nmi` and `rst_req` are low, and the first control write is accepted whatever key it carries.
- R2: While the stored bit 8 (run) is 1, a control write whose bits [15:9] are not the bitwise complement of the stored bits [15:9] is ignored. The control word, the count, the state and the outputs are all left unchanged.
- R3: An accepted write to offset 0x40 stores the full 32-bit value, which then reads back at 0x40. Bit 8 = 1 starts counting and bit 8 = 0 stops it. In both cases the count is reloaded from bits [7:0].
- R4: The start count is bits [7:0], and a value of 0 means 256. With a start count of N, the expiry happens at the N-th tick after the write.
- R5: The count changes only on cycles where `tick_en` is high. With `tick_en` low, no expiry happens.
- R6: On the first expiry (state RUN), `nmi` goes high after that clock edge. The counter reloads 10 and keeps running (state GRACE).
- R7: On an expiry in state GRACE (the 10th grace tick), `rst_req` is high for exactly the one cycle after that edge. The counter then stops (state TRIPPED) and `nmi` stays high.
- R8: An accepted write clears `nmi` and the expiry stage after its edge. If a write and a tick fall in the same cycle, the write wins and that tick is not counted.
- R9: A read at offset 0x44 returns bit 0 = counting (RUN or GRACE) and bit 1 = interrupt stage (GRACE or TRIPPED). All other bits are 0, and other offsets read 0. Reads are combinational from `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow count-enable strobe |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Register offset for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| nmi | output | 1 | Non-maskable interrupt, high in GRACE and TRIPPED |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Every result is due one clock edge after the stimulus that causes it. This covers the stored control word, the state shown in the status word, `nmi` and `rst_req`. A read of `rdata` settles within the same cycle that `addr` is applied. The bench drives inputs on the falling edge and advances a reference model at the rising edge. It compares all outputs 2 ns after that edge, so each expiry is checked in the exact cycle that follows the N-th or 10th tick. The directed cases count ticks to the edge: one tick short of expiry, then the expiring tick. A randomly keyed and ticked stream then runs against the same model.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_GRACE   = 2'd2,
        ST_TRIPPED = 2'd3
    } kwd_state_e;

endpackage

// File: rtl/kwd_keygate.sv
module kwd_keygate #(
    parameter int KEY_W = 7
) (
    input  logic             wr_hit,
    input  logic             armed,
    input  logic [KEY_W-1:0] key_stored,
    input  logic [KEY_W-1:0] key_new,
    output logic             accept
);
    logic key_ok;

    always_comb begin
        key_ok = (key_new == ~key_stored);
        accept = wr_hit && (!armed || key_ok);
    end

    always_comb begin
        if (wr_hit && armed && !key_ok) begin
            assert (!accept) else $error("AST_WRONG_KEY_REJECTED");  // R2
        end
    end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W       = 9,
    parameter int GRACE_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             grace_load,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] GRACE_VAL = CNT_W'(GRACE_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (grace_load) begin
            cnt_q <= GRACE_VAL;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        cnt  = cnt_q;
        last = (cnt_q == CNT_W'(1));
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !grace_load && cnt_q == '0) |=> (cnt_q == '1) == 1'b0) else $error("AST_NO_UNDERFLOW");  // R5
endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       cmd_run,
    input  logic       tick,
    input  logic       last,
    output kwd_state_e state,
    output logic       dec,
    output logic       grace_load,
    output logic       running,
    output logic       nmi_stage,
    output logic       rst_req
);
    kwd_state_e state_q, state_d;
    logic       expire;
    logic       req_q;

    always_comb begin
        dec        = tick && !accept && (state_q == ST_RUN || state_q == ST_GRACE);
        expire     = dec && last;
        grace_load = expire && (state_q == ST_RUN);
    end

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = cmd_run ? ST_RUN : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_RUN:     if (expire) state_d = ST_GRACE;
                ST_GRACE:   if (expire) state_d = ST_TRIPPED;
                ST_TRIPPED: state_d = ST_TRIPPED;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= expire && (state_q == ST_GRACE);
        end
    end

    always_comb begin
        state     = state_q;
        running   = (state_q == ST_RUN) || (state_q == ST_GRACE);
        nmi_stage = (state_q == ST_GRACE) || (state_q == ST_TRIPPED);
        rst_req   = req_q;
    end

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req) else $error("AST_REQ_SINGLE_CYCLE");  // R7
    AST_REQ_ENTERS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> (state_q == ST_TRIPPED)) else $error("AST_REQ_ENTERS_TRIP");  // R7
    AST_FIRST_EXPIRY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && last && !accept) |=> nmi_stage && !rst_req) else $error("AST_FIRST_EXPIRY_NMI");  // R6
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int                 ADDR_W      = 8,
    parameter int                 DATA_W      = 32,
    parameter int                 CNT_FIELD_W = 8,
    parameter int                 KEY_W       = 7,
    parameter int                 GRACE_TICKS = 10,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR   = 8'h40,
    parameter logic [ADDR_W-1:0]  STAT_ADDR   = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              nmi,
    output logic              rst_req
);
    localparam int RUN_POS = CNT_FIELD_W;
    localparam int KEY_LSB = RUN_POS + 1;
    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;
    localparam int CNT_W   = CNT_FIELD_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << CNT_FIELD_W;

    logic [DATA_W-1:0] ctrl_q;
    logic              wr_ctrl;
    logic              accept;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  cnt;
    logic              last;
    logic              dec;
    logic              grace_load;
    logic              running;
    logic              nmi_stage;
    logic              req;
    kwd_state_e        state;

    always_comb begin
        wr_ctrl = wr_en && (addr == CTRL_ADDR);
        if (wdata[CNT_FIELD_W-1:0] == '0) begin
            load_val = FULL_CNT;
        end else begin
            load_val = {1'b0, wdata[CNT_FIELD_W-1:0]};
        end
    end

    kwd_keygate #(.KEY_W(KEY_W)) u_gate (
        .wr_hit     (wr_ctrl),
        .armed      (ctrl_q[RUN_POS]),
        .key_stored (ctrl_q[KEY_MSB:KEY_LSB]),
        .key_new    (wdata[KEY_MSB:KEY_LSB]),
        .accept     (accept)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (accept) begin
            ctrl_q <= wdata;
        end
    end

    kwd_counter #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_val   (load_val),
        .grace_load (grace_load),
        .dec        (dec),
        .cnt        (cnt),
        .last       (last)
    );

    kwd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .cmd_run    (wdata[RUN_POS]),
        .tick       (tick_en),
        .last       (last),
        .state      (state),
        .dec        (dec),
        .grace_load (grace_load),
        .running    (running),
        .nmi_stage  (nmi_stage),
        .rst_req    (req)
    );

    always_comb begin
        nmi     = nmi_stage;
        rst_req = req;
        rdata   = '0;
        if (addr == CTRL_ADDR) begin
            rdata = ctrl_q;
        end else if (addr == STAT_ADDR) begin
            rdata[0] = running;
            rdata[1] = nmi_stage;
        end
    end

    AST_BAD_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && ctrl_q[RUN_POS] && wdata[KEY_MSB:KEY_LSB] != ~ctrl_q[KEY_MSB:KEY_LSB])
        |=> $stable(ctrl_q)) else $error("AST_BAD_KEY_HOLD");  // R2
    AST_ZERO_MEANS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wdata[CNT_FIELD_W-1:0] == '0) |=> (cnt == FULL_CNT)) else $error("AST_ZERO_MEANS_FULL");  // R4
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !accept) |=> $stable(cnt)) else $error("AST_NO_TICK_HOLD");  // R5
    AST_GRACE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> (cnt == CNT_W'(GRACE_TICKS))) else $error("AST_GRACE_RELOAD");  // R6
    AST_WRITE_CLEARS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !nmi && !rst_req) else $error("AST_WRITE_CLEARS_NMI");  // R8
    AST_STATE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(state)) else $error("AST_STATE_KNOWN");  // R9
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nmi;
    logic        rst_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // reference model state: 0 idle, 1 run, 2 grace, 3 tripped
    logic [31:0] m_ctrl = '0;
    int          m_cnt  = 0;
    int          m_st   = 0;
    bit          m_rq   = 0;

    always #4 clk = ~clk;

    keyed_watchdog uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .nmi(nmi), .rst_req(rst_req)
    );

    function automatic logic [31:0] ctrl_word(input logic [6:0] key, input bit run, input logic [7:0] c);
        return {16'h0, key, run, c};
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == 8'h40) return m_ctrl;
        if (a == 8'h44) return {30'd0, (m_st >= 2), (m_st == 1 || m_st == 2)};
        return 32'd0;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge(input bit we, input logic [7:0] a, input logic [31:0] d, input bit tk);
        bit acc;
        acc = we && a == 8'h40 && (!m_ctrl[8] || d[15:9] == ~m_ctrl[15:9]);
        m_rq = 0;
        if (acc) begin
            m_ctrl = d;
            m_cnt  = (d[7:0] == 0) ? 256 : int'(d[7:0]);
            m_st   = d[8] ? 1 : 0;
        end else if (tk && (m_st == 1 || m_st == 2)) begin
            if (m_cnt == 1) begin
                if (m_st == 1) begin
                    m_st = 2; m_cnt = 10;
                end else begin
                    m_st = 3; m_cnt = 0; m_rq = 1;
                end
            end else begin
                m_cnt--;
            end
        end
    endtask

    task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d, input bit tk);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; tick_en = tk;
        @(posedge clk);
        model_edge(we, a, d, tk);
        #2;
        chk({31'd0, nmi}, {31'd0, (m_st >= 2)}, "R6 nmi");
        chk({31'd0, rst_req}, {31'd0, m_rq}, "R7 rst_req");
        chk(rdata, exp_read(a), "R9 rdata");
    endtask

    task automatic idle(input int n, input bit tk);
        for (int i = 0; i < n; i++) step(0, 8'h44, 32'd0, tk);
    endtask

    task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 0; tick_en = 0; addr = a;
        #1;
        chk(rdata, exp, tag);
        @(posedge clk);
        model_edge(0, a, 32'd0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        addr = 8'h40;
        #1;
        chk(rdata, 32'd0, "R1 ctrl after reset");
        chk({30'd0, nmi, rst_req}, 32'd0, "R1 outputs after reset");
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        peek(8'h44, 32'd0, "R1 status stopped");

        // first write accepted with arbitrary key
        step(1, 8'h40, ctrl_word(7'h55, 1, 8'd3), 0);
        peek(8'h40, ctrl_word(7'h55, 1, 8'd3), "R1 first write accepted");
        peek(8'h44, 32'd1, "R3 running after start");
        // wrong key ignored
        step(1, 8'h40, ctrl_word(7'h55, 1, 8'd50), 0);
        peek(8'h40, ctrl_word(7'h55, 1, 8'd3), "R2 wrong key ignored");
        // ticks: 2 no expiry, 3rd expires
        idle(2, 1);
        chk({31'd0, nmi}, 32'd0, "R4 no expiry before Nth tick");
        idle(5, 0);
        chk({31'd0, nmi}, 32'd0, "R5 no ticks no expiry");
        idle(1, 1);
        chk({31'd0, nmi}, 32'd1, "R6 nmi at Nth tick");
        peek(8'h44, 32'd3, "R9 status in grace");
        idle(9, 1);
        chk({31'd0, rst_req}, 32'd0, "R7 no request before 10th grace tick");
        idle(1, 1);
        chk({31'd0, rst_req}, 32'd1, "R7 request after 10th grace tick");
        idle(1, 1);
        chk({31'd0, rst_req}, 32'd0, "R7 request one cycle only");
        chk({31'd0, nmi}, 32'd1, "R7 nmi held when tripped");
        peek(8'h44, 32'd2, "R9 status tripped");
        // accepted stop write clears nmi
        step(1, 8'h40, ctrl_word(~7'h55, 0, 8'd0), 0);
        chk({31'd0, nmi}, 32'd0, "R8 write clears nmi");
        peek(8'h44, 32'd0, "R3 stop command");
        idle(4, 1);
        peek(8'h44, 32'd0, "R3 stays stopped");
        // count field zero means 256 (stored run bit 0, so any key)
        step(1, 8'h40, ctrl_word(7'h11, 1, 8'd0), 0);
        idle(255, 1);
        chk({31'd0, nmi}, 32'd0, "R4 zero count not expired at 255");
        idle(1, 1);
        chk({31'd0, nmi}, 32'd1, "R4 zero count expires at 256");
        // write and tick in same cycle: write wins
        step(1, 8'h40, ctrl_word(~7'h11, 1, 8'd5), 1);
        chk({31'd0, nmi}, 32'd0, "R8 write clears nmi in grace");
        idle(4, 1);
        chk({31'd0, nmi}, 32'd0, "R8 same-cycle tick not counted");
        idle(1, 1);
        chk({31'd0, nmi}, 32'd1, "R8 expiry after 5 ticks");
        peek(8'h10, 32'd0, "R9 other offset reads zero");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit we, tk;
            logic [7:0] a;
            logic [6:0] k;
            logic [7:0] c;
            int r;
            r  = int'($urandom_range(0, 39));
            we = (r < 2);
            tk = ($urandom_range(0, 1) == 1);
            r  = int'($urandom_range(0, 9));
            a  = (r < 7) ? 8'h40 : ((r < 9) ? 8'h44 : 8'h10);
            k  = ($urandom_range(0, 3) != 0) ? ~m_ctrl[15:9] : 7'($urandom());
            c  = ($urandom_range(0, 15) == 0) ? 8'd0 : 8'($urandom_range(1, 24));
            step(we, a, ctrl_word(k, ($urandom_range(0, 4) != 0), c), tk);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule